// File: doc/BRIEF.md
# Watchdog Timer with Pre-Timeout Warning

This block is a memory-mapped watchdog for a system that must be forced back to a known state when its software stops responding. Software programs a timeout in coarse 128 ms units, switches the timer on through a control register, and from then on must keep writing the reload register. Each such write starts the countdown again. When software falls silent and the countdown runs out, the block raises a non-maskable warning line. This gives a handler time to record the failure. If no reload write arrives during a fixed warning window (nine seconds' worth of ticks by default), the block drives a system reset pulse and then switches itself off.

The coarse tick comes from an internal prescaler that divides the system clock. The division ratio is a parameter, so a test build can use a small ratio. Three states carry the timer function: ST_OFF (stopped), ST_COUNT (main countdown) and ST_WARN (warning window, warning line high). A fourth state, ST_FIRE, holds the reset pulse. The transitions are:
- arm: ST_OFF to ST_COUNT, on a control write with the enable bit set.
- expire: ST_COUNT to ST_WARN, when the count runs out.
- kick: ST_COUNT or ST_WARN to ST_COUNT, on a reload write.
- halt: ST_COUNT or ST_WARN to ST_OFF, on a control write with the enable bit clear.
- bite: ST_WARN to ST_FIRE, when the warning window runs out.
- recover: ST_FIRE to ST_OFF, once the reset pulse has ended.

Software uses a 30 to 600 second range and converts seconds to units as seconds × 1000 / 128. The hardware takes any 16-bit value.

Top module: `wdog_pretimeout`

## Requirements
- R1: After reset, `nmi_o` and `sys_rst_o` are low, and reads at offsets 0x70, 0x72 and 0x74 return 0.
- R2: A read at 0x70 returns the last value written to the reload register, and a read at 0x72 returns the last value written to the control register. A read at 0x74 returns the current tick count. Any other offset reads 0.
- R3: The count at 0x74 holds the loaded value for TICK_DIV clocks after the timer starts, then drops by one every TICK_DIV clocks.
- R4: A control write with bit 0 = 1 while the timer is stopped (for example 0x85) starts the countdown from the reload register. The same write while the timer is running leaves the count unchanged.
- R5: `nmi_o` rises TICK_DIV × max(R,1) clocks after the start or the last reload write, where R is the loaded value. It stays high until a reload write, a stop, or the reset pulse.
- R6: `sys_rst_o` rises WARN_TICKS × TICK_DIV clocks after `nmi_o` rises, and `nmi_o` falls on the same clock. `sys_rst_o` stays high for exactly RST_PULSE clocks. Afterwards the timer is stopped, and control bit 0 reads 0 with the other control bits kept (0x85 reads back as 0x84).
- R7: A reload write while the timer is counting or warning restarts the countdown from the written value and realigns the tick. If `nmi_o` was high, it falls on the next clock.
- R8: A reload write while the timer is stopped only stores the value. No output changes and the count readout does not change until the next start.
- R9: A control write with bit 0 = 0 while the timer is counting or warning stops it on the next clock. `nmi_o` goes low and no reset follows.
- R10: Bus writes during the reset pulse, including a stop, do not change the pulse length. The written register values are still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe, one clock per write |
| bus_addr_i | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| nmi_o | output | 1 | Non-maskable warning, level |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The full expiry path is swept over reload values 0 through 6 and 10. Value 0 separates the clamp-to-one rule from plain arithmetic, and the larger values show that the tick spacing scales linearly rather than being off by one tick. Each edge of the warning and reset lines is sampled one clock before and on the clock where it is predicted. Separate patterns do the following:
- send reload writes during counting and during warning, which tells a count restart apart from a warning clear;
- send stops during counting and during warning;
- send a reload write while stopped, which must not start the timer;
- send a repeated enable while running;
- send writes during the reset pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_WARN  = 2'd2,
        ST_FIRE  = 2'd3
    } wdt_state_e;

    localparam logic [7:0] OFS_RELOAD = 8'h70;
    localparam logic [7:0] OFS_CTRL   = 8'h72;
    localparam logic [7:0] OFS_COUNT  = 8'h74;

    localparam int CTRL_EN_BIT = 0;

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int TICK_DIV = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_q;

    assign tick_o = (div_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else if (clr_i || tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + CW'(1);
        end
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] count_i,
    input  logic              en_clr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] reload_q_o,
    output logic              reload_wr_o,
    output logic              ctrl_wr_o
);
    logic [DATA_W-1:0] ctrl_q;
    logic hit_reload, hit_ctrl, hit_count;

    always_comb begin
        hit_reload = (addr_i == ADDR_W'(OFS_RELOAD));
        hit_ctrl   = (addr_i == ADDR_W'(OFS_CTRL));
        hit_count  = (addr_i == ADDR_W'(OFS_COUNT));
    end

    assign reload_wr_o = we_i && hit_reload;
    assign ctrl_wr_o   = we_i && hit_ctrl;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            reload_q_o <= '0;
        end else if (reload_wr_o) begin
            reload_q_o <= wdata_i;
        end
    end

    // A bus write takes priority over the automatic enable clear.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
        end else if (ctrl_wr_o) begin
            ctrl_q <= wdata_i;
        end else if (en_clr_i) begin
            ctrl_q[CTRL_EN_BIT] <= 1'b0;
        end
    end

    always_comb begin
        if (hit_reload) begin
            rdata_o = reload_q_o;
        end else if (hit_ctrl) begin
            rdata_o = ctrl_q;
        end else if (hit_count) begin
            rdata_o = count_i;
        end else begin
            rdata_o = '0;
        end
    end
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int WARN_TICKS = 70,
    parameter int RST_PULSE  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              kick_i,
    input  logic [DATA_W-1:0] reload_val_i,
    input  logic [DATA_W-1:0] kick_val_i,
    output logic              presc_clr_o,
    output logic              en_clr_o,
    output logic [DATA_W-1:0] count_o,
    output logic              nmi_o,
    output logic              sys_rst_o
);
    localparam int PW = (RST_PULSE > 1) ? $clog2(RST_PULSE) : 1;
    localparam logic [PW-1:0]     PULSE_LAST = PW'(RST_PULSE - 1);
    localparam logic [DATA_W-1:0] WARN_LOAD  = DATA_W'(WARN_TICKS);

    wdt_state_e        state_q, state_d;
    logic [DATA_W-1:0] count_q, count_d;
    logic [PW-1:0]     pcnt_q, pcnt_d;
    logic              run_phase, expiring;

    assign run_phase = (state_q == ST_COUNT) || (state_q == ST_WARN);
    assign expiring  = (count_q <= DATA_W'(1));

    // Next state: arm, expire, kick, halt, bite, recover
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        pcnt_d  = pcnt_q;
        unique case (state_q)
            ST_OFF: begin
                if (start_i) begin
                    state_d = ST_COUNT;
                    count_d = reload_val_i;
                end
            end
            ST_COUNT, ST_WARN: begin
                if (stop_i) begin
                    state_d = ST_OFF;
                end else if (kick_i) begin
                    state_d = ST_COUNT;
                    count_d = kick_val_i;
                end else if (tick_i) begin
                    if (!expiring) begin
                        count_d = count_q - DATA_W'(1);
                    end else if (state_q == ST_COUNT) begin
                        state_d = ST_WARN;
                        count_d = WARN_LOAD;
                    end else begin
                        state_d = ST_FIRE;
                        count_d = '0;
                        pcnt_d  = '0;
                    end
                end
            end
            ST_FIRE: begin
                if (pcnt_q == PULSE_LAST) begin
                    state_d = ST_OFF;
                end else begin
                    pcnt_d = pcnt_q + PW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
            count_q <= '0;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            pcnt_q  <= pcnt_d;
        end
    end

    always_comb begin
        nmi_o       = (state_q == ST_WARN);
        sys_rst_o   = (state_q == ST_FIRE);
        en_clr_o    = (state_q == ST_FIRE) && (pcnt_q == PULSE_LAST);
        presc_clr_o = ((state_q == ST_OFF) && start_i) ||
                      (run_phase && !stop_i && kick_i);
        count_o     = count_q;
    end
endmodule

// File: rtl/wdog_pretimeout.sv
module wdog_pretimeout
    import wdt_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 8,
    parameter int TICK_DIV   = 12800000,
    parameter int WARN_TICKS = 70,
    parameter int RST_PULSE  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              nmi_o,
    output logic              sys_rst_o
);
    logic [DATA_W-1:0] reload_q, count;
    logic reload_wr, ctrl_wr, en_clr, presc_clr, tick;
    logic start, stop;

    assign start = ctrl_wr &&  bus_wdata_i[CTRL_EN_BIT];
    assign stop  = ctrl_wr && !bus_wdata_i[CTRL_EN_BIT];

    wdt_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (bus_we_i),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .count_i     (count),
        .en_clr_i    (en_clr),
        .rdata_o     (bus_rdata_o),
        .reload_q_o  (reload_q),
        .reload_wr_o (reload_wr),
        .ctrl_wr_o   (ctrl_wr)
    );

    wdt_prescale #(
        .TICK_DIV (TICK_DIV)
    ) u_presc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (presc_clr),
        .tick_o (tick)
    );

    wdt_fsm #(
        .DATA_W     (DATA_W),
        .WARN_TICKS (WARN_TICKS),
        .RST_PULSE  (RST_PULSE)
    ) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick),
        .start_i      (start),
        .stop_i       (stop),
        .kick_i       (reload_wr),
        .reload_val_i (reload_q),
        .kick_val_i   (bus_wdata_i),
        .presc_clr_o  (presc_clr),
        .en_clr_o     (en_clr),
        .count_o      (count),
        .nmi_o        (nmi_o),
        .sys_rst_o    (sys_rst_o)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 8,
    parameter int RST_PULSE = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              nmi_o,
    input logic              sys_rst_o
);
    logic [31:0] rst_len;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rst_len <= '0;
        end else if (sys_rst_o) begin
            rst_len <= rst_len + 32'd1;
        end else begin
            rst_len <= '0;
        end
    end

    // R2
    reload_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == ADDR_W'(OFS_RELOAD)) |=>
        (bus_addr_i != ADDR_W'(OFS_RELOAD) || bus_rdata_o == $past(bus_wdata_i)));

    // R5
    warn_before_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sys_rst_o) |-> $past(nmi_o));

    // R6
    outputs_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({nmi_o, sys_rst_o}));

    // R6
    pulse_length_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sys_rst_o) |-> (rst_len == 32'(RST_PULSE)));

    // R7
    kick_clears_warn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == ADDR_W'(OFS_RELOAD) && nmi_o) |=> !nmi_o);

    // R9
    halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == ADDR_W'(OFS_CTRL) && !bus_wdata_i[CTRL_EN_BIT] && !sys_rst_o)
        |=> (!nmi_o && !sys_rst_o));
endmodule

bind wdog_pretimeout wdt_checker #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .RST_PULSE (RST_PULSE)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .nmi_o       (nmi_o),
    .sys_rst_o   (sys_rst_o)
);

// File: tb/wdog_pretimeout_test.sv
module wdog_pretimeout_test;
    localparam int CLK_NS = 10;
    localparam int D = 4;
    localparam int W = 3;
    localparam int P = 5;
    localparam logic [7:0] A_REL = 8'h70;
    localparam logic [7:0] A_CTL = 8'h72;
    localparam logic [7:0] A_CNT = 8'h74;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic nmi, srst;
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    wdog_pretimeout #(
        .DATA_W(16), .ADDR_W(8), .TICK_DIV(D), .WARN_TICKS(W), .RST_PULSE(P)
    ) uut (
        .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .nmi_o(nmi), .sys_rst_o(srst)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_expiry(input int r);
        logic [15:0] v;
        int eff;
        eff = (r == 0) ? 1 : r;
        wr(A_REL, 16'(r));
        wr(A_CTL, 16'h0085);
        wait_n(eff*D - 1);
        chk("R5 nmi before due", {15'd0, nmi}, 16'd0);
        wait_n(1);
        chk("R5 nmi at due", {15'd0, nmi}, 16'd1);
        wait_n(W*D - 1);
        chk("R6 rst before due", {15'd0, srst}, 16'd0);
        chk("R5 nmi held", {15'd0, nmi}, 16'd1);
        wait_n(1);
        chk("R6 rst at due", {15'd0, srst}, 16'd1);
        chk("R6 nmi drops", {15'd0, nmi}, 16'd0);
        wait_n(P - 1);
        chk("R6 rst held", {15'd0, srst}, 16'd1);
        wait_n(1);
        chk("R6 rst ends", {15'd0, srst}, 16'd0);
        rd(A_CTL, v);
        chk("R6 enable cleared", v, 16'h0084);
        wait_n(2*D*(W + eff));
        chk("R6 stays off", {14'd0, nmi, srst}, 16'd0);
    endtask

    initial begin
        logic [15:0] v, c0;
        wait_n(2);
        rd(A_REL, v); chk("R1 reload reset", v, 16'h0000);
        rd(A_CTL, v); chk("R1 ctrl reset", v, 16'h0000);
        rd(A_CNT, v); chk("R1 count reset", v, 16'h0000);
        chk("R1 outputs reset", {14'd0, nmi, srst}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1 outputs after reset", {14'd0, nmi, srst}, 16'd0);

        // R2 register readback
        wr(A_REL, 16'hABCD);
        rd(A_REL, v); chk("R2 reload readback", v, 16'hABCD);
        @(negedge clk);
        wr(A_CTL, 16'h1234);
        rd(A_CTL, v); chk("R2 ctrl readback", v, 16'h1234);
        addr = 8'h76; #1; chk("R2 unmapped reads zero", rdata, 16'h0000);
        @(negedge clk);

        // R3 tick rate and count readout
        wr(A_REL, 16'd10);
        wr(A_CTL, 16'h0085);
        rd(A_CNT, v); chk("R3 count loaded", v, 16'd10);
        for (int k = 1; k <= 9; k++) begin
            wait_n(D - 1);
            rd(A_CNT, v); chk("R3 count held within tick", v, 16'(11 - k));
            @(negedge clk);
            rd(A_CNT, v); chk("R3 count per tick", v, 16'(10 - k));
        end
        // R4 enable while running does not restart
        @(negedge clk);
        wr(A_CTL, 16'h0085);
        rd(A_CNT, v); chk("R4 re-enable keeps count", v, 16'd1);
        @(negedge clk);
        wr(A_CTL, 16'h0084);
        chk("R9 stop in count", {14'd0, nmi, srst}, 16'd0);

        // R5 and R6 sweep over reload values
        for (int r = 0; r <= 6; r++) run_expiry(r);
        run_expiry(10);

        // R7 kick while counting
        wr(A_REL, 16'd3);
        wr(A_CTL, 16'h0085);
        wait_n(2*D);
        wr(A_REL, 16'd4);
        wait_n(4*D - 1);
        chk("R7 kick restarts count", {15'd0, nmi}, 16'd0);
        wait_n(1);
        chk("R7 nmi after kicked span", {15'd0, nmi}, 16'd1);
        // R7 kick while warning
        wait_n(D);
        wr(A_REL, 16'd2);
        chk("R7 kick clears nmi", {15'd0, nmi}, 16'd0);
        rd(A_CNT, v); chk("R7 count reloaded", v, 16'd2);
        @(negedge clk);
        wait_n(2*D - 2);
        chk("R7 nmi before new due", {15'd0, nmi}, 16'd0);
        wait_n(1);
        chk("R7 nmi at new due", {15'd0, nmi}, 16'd1);
        // R9 stop while warning
        wr(A_CTL, 16'h0084);
        chk("R9 stop clears nmi", {15'd0, nmi}, 16'd0);
        wait_n(W*D + P + 8);
        chk("R9 no reset after stop", {14'd0, nmi, srst}, 16'd0);

        // R8 reload while stopped
        rd(A_CNT, c0);
        @(negedge clk);
        wr(A_REL, 16'd2);
        wait_n(40);
        chk("R8 no output when stopped", {14'd0, nmi, srst}, 16'd0);
        rd(A_CNT, v); chk("R8 count untouched", v, c0);
        @(negedge clk);
        wr(A_CTL, 16'h0085);
        wait_n(2*D - 1);
        chk("R8 start from stored", {15'd0, nmi}, 16'd0);
        wait_n(1);
        chk("R8 nmi from stored value", {15'd0, nmi}, 16'd1);
        wr(A_CTL, 16'h0084);

        // R9 stop while counting
        wr(A_REL, 16'd3);
        wr(A_CTL, 16'h0085);
        wait_n(D);
        wr(A_CTL, 16'h0084);
        wait_n(3*D + W*D + P + 10);
        chk("R9 stopped count stays quiet", {14'd0, nmi, srst}, 16'd0);

        // R10 writes during reset pulse
        wr(A_REL, 16'd1);
        wr(A_CTL, 16'h0085);
        wait_n(D + W*D);
        chk("R10 pulse begins", {15'd0, srst}, 16'd1);
        wr(A_CTL, 16'h0000);
        wr(A_REL, 16'h0040);
        wait_n(P - 3);
        chk("R10 stop ignored in pulse", {15'd0, srst}, 16'd1);
        wait_n(1);
        chk("R10 pulse length kept", {15'd0, srst}, 16'd0);
        rd(A_REL, v); chk("R10 reload stored in pulse", v, 16'h0040);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule